// File: doc/BRIEF.md
# Pulse-Distance Remote Bit Decoder

This block takes a demodulated infrared remote-control waveform and turns it into data bits. It measures the time from one falling edge of the input to the next, in units of a sampling tick, and compares that time with a programmable threshold. A cycle longer than the threshold gives a 1; any other cycle gives a 0. Decoded bits are stored in order of arrival in a receive register, and a counter tracks how many have been stored.

Reception has no fixed length. It ends when a programmed limit runs out. One limit is the longest allowed gap between falling edges. The other is the longest allowed low level after a falling edge. A one-cycle completion interrupt then fires, and a cause code reports which limit ended the frame. As an option, the block can also pulse an interrupt on every falling edge, so that software can time the bits itself. All configuration and status are plain ports.

Top module: `pd_bit_decoder`

## Requirements
- R1: After reset, busy, done_irq, edge_irq, end_cause, rx_count and rx_data are all zero.
- R2: The first falling edge seen while idle sets busy and starts the cycle count. It produces no bit, so a frame with only that edge completes with rx_count = 0.
- R3: On each later falling edge the block counts the sampling ticks since the previous edge. The bit is 1 when that count is strictly greater than thresh, and 0 when it is equal to or below thresh.
- R4: Bits are stored LSB-first. The first bit goes to rx_data bit 0, and rx_count increments by one for each stored bit.
- R5: When the tick count since the last falling edge would pass max_cycle, reception ends. done_irq pulses for one clock, busy drops and end_cause becomes 2'b01.
- R6: When the input has stayed low for more than max_low ticks, reception ends. done_irq pulses and end_cause becomes 2'b10. If both limits run out on the same tick, the code is 2'b01.
- R7: A limit of zero disables that completion condition.
- R8: rx_count stops at 64. Bits that arrive after the 64th are dropped, and the first 64 bits are kept.
- R9: When edge_irq_en is 1, edge_irq pulses once for each falling edge of the input. When edge_irq_en is 0, edge_irq never pulses.
- R10: The falling edge that starts a new reception clears rx_data, rx_count and end_cause.
- R11: The cycle and low-width counters advance only on clocks where tick is 1, so all times are measured in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sampling-tick enable; sets the time base |
| rx_in | input | 1 | Demodulated remote-control input (asynchronous) |
| edge_irq_en | input | 1 | Enables the per-falling-edge interrupt |
| thresh | input | 7 | 0/1 decision threshold, in ticks |
| max_cycle | input | 8 | Maximum edge-to-edge cycle, in ticks; 0 disables it |
| max_low | input | 8 | Maximum low width, in ticks; 0 disables it |
| busy | output | 1 | Reception in progress |
| done_irq | output | 1 | One-clock pulse when reception completes |
| edge_irq | output | 1 | One-clock pulse on each falling edge, when enabled |
| end_cause | output | 2 | 01 = maximum cycle, 10 = low width |
| rx_data | output | 64 | Received bits, LSB-first |
| rx_count | output | 7 | Number of stored bits |

## Verification
The hardest cases to reach are the threshold boundary and a frame that never ends. For the boundary, the bench drives two edge spacings that come to exactly thresh ticks and to thresh+1 ticks, which gives the bit pair 0 then 1. For the frame that never ends, the maximum-cycle limit is set to zero and the input is held high for hundreds of ticks. A run of 70 bits drives the counter past its saturation point. A run with a divided tick shows that spacings which would all decode as 1 when measured in clocks decode correctly when measured in ticks.

// File: rtl/pd_bit_decoder.sv
module pd_bit_decoder #(
  parameter int THR_W  = 7,
  parameter int LIM_W  = 8,
  parameter int DATA_W = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick,
  input  logic                             rx_in,
  input  logic                             edge_irq_en,
  input  logic [THR_W-1:0]                 thresh,
  input  logic [LIM_W-1:0]                 max_cycle,
  input  logic [LIM_W-1:0]                 max_low,
  output logic                             busy,
  output logic                             done_irq,
  output logic                             edge_irq,
  output logic [1:0]                       end_cause,
  output logic [DATA_W-1:0]                rx_data,
  output logic [$clog2(DATA_W+1)-1:0]      rx_count
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [2:0]       sync_q;
  logic [LIM_W-1:0] cyc_q, low_q;

  wire             fall      = sync_q[2] & ~sync_q[1];
  wire             level_low = ~sync_q[1];
  wire [LIM_W-1:0] cyc_inc   = (&cyc_q) ? cyc_q : cyc_q + 1'b1;
  wire [LIM_W-1:0] low_inc   = (&low_q) ? low_q : low_q + 1'b1;
  wire             bit_val   = int'(cyc_q) > int'(thresh);
  wire             hit_max   = (max_cycle != '0) && (cyc_inc > max_cycle);
  wire             hit_low   = (max_low != '0) && level_low && (low_inc > max_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], rx_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done_irq  <= 1'b0;
      edge_irq  <= 1'b0;
      end_cause <= 2'b00;
      rx_data   <= '0;
      rx_count  <= '0;
      cyc_q     <= '0;
      low_q     <= '0;
    end else begin
      done_irq <= 1'b0;
      edge_irq <= fall & edge_irq_en;
      if (fall) begin
        cyc_q <= '0;
        low_q <= '0;
        if (!busy) begin
          busy      <= 1'b1;
          rx_data   <= '0;
          rx_count  <= '0;
          end_cause <= 2'b00;
        end else if (rx_count < FULL) begin
          rx_data  <= rx_data | (DATA_W'(bit_val) << rx_count);
          rx_count <= rx_count + 1'b1;
        end
      end else begin
        if (!level_low) low_q <= '0;
        if (busy && tick) begin
          cyc_q <= cyc_inc;
          low_q <= level_low ? low_inc : '0;
          if (hit_max || hit_low) begin
            busy      <= 1'b0;
            done_irq  <= 1'b1;
            end_cause <= hit_max ? 2'b01 : 2'b10;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pd_bit_decoder_chk.sv
module pd_bit_decoder_chk #(
  parameter int LIM_W = 8,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             fall,
  input logic             busy,
  input logic             done_irq,
  input logic             edge_irq,
  input logic             edge_irq_en,
  input logic [1:0]       end_cause,
  input logic [LIM_W-1:0] cyc_q,
  input logic [LIM_W-1:0] max_cycle,
  input logic [CNT_W-1:0] rx_count
);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy && $past(busy));
  a_r6_cause_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (end_cause == 2'b01 || end_cause == 2'b10));
  a_r7_zero_max_off: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && end_cause == 2'b01) |-> $past(max_cycle) != '0);
  a_r8_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(64));
  a_r9_edge_gate: assert property (@(posedge clk) disable iff (!rst_n)
    edge_irq |-> $past(edge_irq_en) && $past(fall));
  a_r11_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !fall) |=> $stable(cyc_q));
endmodule

bind pd_bit_decoder pd_bit_decoder_chk #(.LIM_W(LIM_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .fall(fall), .busy(busy),
  .done_irq(done_irq), .edge_irq(edge_irq), .edge_irq_en(edge_irq_en),
  .end_cause(end_cause), .cyc_q(cyc_q), .max_cycle(max_cycle), .rx_count(rx_count)
);

// File: tb/pd_bit_decoder_tb.sv
module pd_bit_decoder_tb_top;
  logic clk = 0, rst_n = 0, tick = 1, rx_in = 1, edge_irq_en = 0;
  logic [6:0] thresh = 7'd20;
  logic [7:0] max_cycle = 8'd40, max_low = 8'd10;
  logic busy, done_irq, edge_irq;
  logic [1:0] end_cause;
  logic [63:0] rx_data;
  logic [6:0] rx_count;
  int errors = 0, checks = 0, edge_cnt = 0, tick_div = 1, tcnt = 0;
  int p0 = 12, p1 = 30, lw = 4;
  bit seen_done;

  always #4 clk = ~clk;

  pd_bit_decoder dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
    .edge_irq_en(edge_irq_en), .thresh(thresh), .max_cycle(max_cycle), .max_low(max_low),
    .busy(busy), .done_irq(done_irq), .edge_irq(edge_irq), .end_cause(end_cause),
    .rx_data(rx_data), .rx_count(rx_count));

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % tick_div;
    tick = (tcnt == 0);
    if (edge_irq) edge_cnt++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int period);
    rx_in = 0; repeat (lw) @(negedge clk);
    rx_in = 1; repeat (period - lw) @(negedge clk);
  endtask

  task automatic frame(input logic [69:0] bits, input int n, input bit end_low);
    for (int i = 0; i < n; i++) pulse(bits[i] ? p1 : p0);
    rx_in = 0;
    if (!end_low) begin repeat (lw) @(negedge clk); rx_in = 1; end
  endtask

  task automatic wait_done(input int lim);
    seen_done = 0;
    for (int i = 0; i < lim && !seen_done; i++) begin
      @(negedge clk);
      if (done_irq) seen_done = 1;
    end
    rx_in = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0); check("R1 done", done_irq, 0);
    check("R1 edge", edge_irq, 0); check("R1 cause", end_cause, 0);
    check("R1 count", rx_count, 0); check("R1 data", rx_data, 0);
  endtask

  task automatic t_single_edge;
    frame('0, 0, 0); wait_done(300);
    check("R2 done", seen_done, 1); check("R2 count", rx_count, 0);
    check("R5 cause", end_cause, 2'b01); check("R5 busy", busy, 0);
  endtask

  task automatic t_byte_max;
    edge_cnt = 0; edge_irq_en = 1;
    frame(70'hA5, 8, 0); wait_done(300);
    check("R4 data", rx_data, 64'hA5); check("R4 count", rx_count, 8);
    check("R5 cause", end_cause, 2'b01); check("R9 edges", edge_cnt, 9);
    edge_irq_en = 0;
  endtask

  task automatic t_low_end;
    edge_cnt = 0;
    frame(70'h16, 5, 1); wait_done(300);
    check("R6 done", seen_done, 1); check("R6 cause", end_cause, 2'b10);
    check("R10 count", rx_count, 5); check("R10 data", rx_data, 64'h16);
    check("R9 no edges", edge_cnt, 0);
  endtask

  task automatic t_threshold;
    rx_in = 0; repeat (lw) @(negedge clk); rx_in = 1; repeat (21 - lw) @(negedge clk);
    rx_in = 0; repeat (lw) @(negedge clk); rx_in = 1; repeat (22 - lw) @(negedge clk);
    frame('0, 0, 0); wait_done(300);
    check("R3 equal->0 above->1", rx_data, 64'h2); check("R3 count", rx_count, 2);
  endtask

  task automatic t_zero_max;
    max_cycle = 0;
    frame(70'h3, 2, 0);
    seen_done = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (done_irq) seen_done = 1; end
    check("R7 no end", seen_done, 0); check("R7 busy", busy, 1);
    rx_in = 0; wait_done(300);
    check("R7 low ends", end_cause, 2'b10); check("R7 count", rx_count, 3);
    check("R7 data", rx_data, 64'h7);
    max_cycle = 40; max_low = 0;
    frame(70'h1, 1, 1); wait_done(300);
    check("R7 low off", end_cause, 2'b01); check("R7 count2", rx_count, 1);
    max_low = 10;
  endtask

  task automatic t_saturate;
    logic [69:0] b;
    for (int i = 0; i < 70; i++) b[i] = (i % 3 == 0);
    frame(b, 70, 0); wait_done(300);
    check("R8 count", rx_count, 64); check("R8 data", rx_data, b[63:0]);
  endtask

  task automatic t_ticks;
    tick_div = 4; thresh = 5; max_cycle = 20; max_low = 0; p0 = 8; p1 = 40;
    frame(70'h6, 4, 0); wait_done(400);
    check("R11 data", rx_data, 64'h6); check("R11 count", rx_count, 4);
    tick_div = 1; thresh = 20; max_cycle = 40; max_low = 10; p0 = 12; p1 = 30;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_single_edge;
    t_byte_max;
    t_low_end;
    t_threshold;
    t_zero_max;
    t_saturate;
    t_ticks;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule